// File: doc/BRIEF.md
# DRAM Idle Low-Power Sequencer

This block watches an idle indication from the memory bus, counted on the DFI clock (half the DRAM clock rate), and walks the memory subsystem into progressively deeper low-power states while the bus stays quiet. There are five depths, from shallowest to deepest:

- power-down
- self-refresh
- self-refresh with controller clock gating
- self-refresh power-down, which only an LPDDR4 device may use
- full standby, with every clock gated

Each depth has its own programmable limit. The power-down and standby limits are counted in raw DFI cycles. The three self-refresh limits are counted in units of 1024 cycles. A limit of zero turns that depth off.

When bus traffic appears in any low-power state, the block leaves through a handshake. It first removes clock gating if gating is on. It then raises an exit request and holds it until the exit acknowledge arrives. Only after that does it report the active state. The surrounding controller issues the actual DRAM commands for each one-cycle entry strobe and does not send traffic while the state code is non-zero.

Top module: `lp_idle_ctrl`

## Requirements
- R1: After a synchronous reset, `st_code` is 0, `enter_stb` is all zero, and both `clk_gate_en` and `exit_req` are low.
- R2: With `bus_busy` low from the cycle after edge E onward, power-down (code 1) is reported after edge E+`lim_pdn`+1. The limit is in raw cycles.
- R3: Self-refresh (code 2) and self-refresh with gating (code 3) are reported after edge E+`lim`×1024+1, using their own limits.
- R4: Self-refresh power-down (code 4) is entered after edge E+`lim_spdn`×1024+1, and only when `mem_is_lp4` is high. Otherwise it is skipped.
- R5: Standby (code 5) is entered after edge E+`lim_stby`+1, in raw cycles. `clk_gate_en` is high exactly while the block sits in code 3, 4 or 5 and no exit is under way.
- R6: A limit of zero disables its state: that code is never reported.
- R7: While idle continues, the block only moves deeper. It goes straight to the deepest state whose limit has been reached, skipping shallower ones. Any busy cycle restarts the idle count from zero.
- R8: A busy cycle in a low-power state starts the exit. If gating is on, `clk_gate_en` drops one cycle before `exit_req` rises; otherwise `exit_req` rises on the next edge. `exit_req` stays high until `exit_done` is sampled. The edge after that reports code 0 and lowers `exit_req`.
- R9: The limit inputs are captured only while the code is 0. Changing them in a low-power state has no effect until the block is back in code 0.
- R10: `st_code` encodes the states as follows: 0 active, 1 power-down, 2 self-refresh, 3 self-refresh with gating, 4 self-refresh power-down, 5 standby.
- R11: Each entry into a low-power state pulses `enter_stb` for exactly the cycle in which the new code first appears. Bit k-1 marks entry into code k, and at most one bit is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | DFI-rate clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_busy | input | 1 | Bus request or activity this cycle |
| mem_is_lp4 | input | 1 | Memory is LPDDR4; allows code 4 |
| lim_pdn | input | PD_W | Power-down idle limit, raw cycles |
| lim_sref | input | SR_W | Self-refresh limit, ×1024 cycles |
| lim_sgate | input | SR_W | Self-refresh plus gating limit, ×1024 cycles |
| lim_spdn | input | SR_W | Self-refresh power-down limit, ×1024 cycles |
| lim_stby | input | STBY_W | Standby limit, raw cycles |
| exit_done | input | 1 | Acknowledge that the low-power exit has completed |
| exit_req | output | 1 | Exit request, held until acknowledged |
| clk_gate_en | output | 1 | Controller/PHY/DRAM clock gate enable |
| enter_stb | output | 5 | One-cycle entry strobe, bit k-1 for code k |
| st_code | output | 3 | Current state code |

## Verification
A corrupted idle count or a mis-scaled limit shows up as a state code that changes at the wrong cycle. The bench times every code change to the exact edge, so an error of even one cycle is caught on the first transition. A wrong exit phase shows within two cycles of the busy request, as `exit_req` rising while the clocks are still gated, or as code 0 appearing without an acknowledge. A stale or leaking limit capture only shows later, as a state that is entered too early or never entered during the next idle period.

// File: rtl/lp_idle_pkg.sv
package lp_idle_pkg;

    localparam int NUM_LP = 5;

    typedef enum logic [2:0] {
        LP_ACTIVE    = 3'd0,
        LP_PDOWN     = 3'd1,
        LP_SREF      = 3'd2,
        LP_SREF_GATE = 3'd3,
        LP_SREF_PD   = 3'd4,
        LP_STANDBY   = 3'd5
    } lp_code_e;

    typedef enum logic [1:0] {
        PH_RUN    = 2'd0,
        PH_UNGATE = 2'd1,
        PH_WAIT   = 2'd2
    } exit_ph_e;

    typedef struct packed {
        lp_code_e code;
        exit_ph_e phase;
        logic     gate;
        logic     xreq;
    } lp_ctl_t;

    function automatic int max3(input int a, input int b, input int c);
        int m;
        m = (a > b) ? a : b;
        return (m > c) ? m : c;
    endfunction

    function automatic logic is_gated(input lp_code_e c);
        return (c >= LP_SREF_GATE);
    endfunction

    function automatic logic [NUM_LP-1:0] stb_of(input lp_code_e c);
        logic [NUM_LP-1:0] v;
        v = '0;
        for (int i = 0; i < NUM_LP; i++) begin
            if (c == lp_code_e'(3'(i + 1))) v[i] = 1'b1;
        end
        return v;
    endfunction

endpackage

// File: rtl/lp_idle_counter.sv
module lp_idle_counter #(
    parameter int CNT_W = 19
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clear,
    output logic [CNT_W-1:0] cnt
);
    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    always_ff @(posedge clk) begin
        if (rst || clear) begin
            cnt <= '0;
        end else if (cnt != CNT_MAX) begin
            cnt <= cnt + 1'b1;
        end
    end
endmodule

// File: rtl/lp_idle_select.sv
module lp_idle_select
    import lp_idle_pkg::*;
#(
    parameter int PD_W     = 8,
    parameter int SR_W     = 8,
    parameter int STBY_W   = 16,
    parameter int SCALE_SH = 10,
    parameter int CNT_W    = 19
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              load,
    input  logic              mem_is_lp4,
    input  logic [PD_W-1:0]   lim_pdn,
    input  logic [SR_W-1:0]   lim_sref,
    input  logic [SR_W-1:0]   lim_sgate,
    input  logic [SR_W-1:0]   lim_spdn,
    input  logic [STBY_W-1:0] lim_stby,
    input  logic [CNT_W-1:0]  cnt,
    output lp_code_e          target
);
    typedef struct packed {
        logic [PD_W-1:0]   pdn;
        logic [SR_W-1:0]   sref;
        logic [SR_W-1:0]   sgate;
        logic [SR_W-1:0]   spdn;
        logic [STBY_W-1:0] stby;
    } lim_set_t;

    lim_set_t          shadow;
    logic [CNT_W-1:0]  lim [NUM_LP];
    logic [NUM_LP-1:0] en;
    logic [NUM_LP-1:0] hit;

    always_ff @(posedge clk) begin
        if (rst) begin
            shadow <= '0;
        end else if (load) begin
            shadow <= '{pdn: lim_pdn, sref: lim_sref, sgate: lim_sgate,
                        spdn: lim_spdn, stby: lim_stby};
        end
    end

    always_comb begin
        lim[0] = CNT_W'(shadow.pdn);
        lim[1] = CNT_W'({shadow.sref,  {SCALE_SH{1'b0}}});
        lim[2] = CNT_W'({shadow.sgate, {SCALE_SH{1'b0}}});
        lim[3] = CNT_W'({shadow.spdn,  {SCALE_SH{1'b0}}});
        lim[4] = CNT_W'(shadow.stby);
        en[0]  = (shadow.pdn   != '0);
        en[1]  = (shadow.sref  != '0);
        en[2]  = (shadow.sgate != '0);
        en[3]  = (shadow.spdn  != '0) && mem_is_lp4;
        en[4]  = (shadow.stby  != '0);
    end

    for (genvar i = 0; i < NUM_LP; i++) begin : g_hit
        assign hit[i] = en[i] && (cnt >= lim[i]);
    end

    always_comb begin
        target = LP_ACTIVE;
        for (int i = 0; i < NUM_LP; i++) begin
            if (hit[i]) target = lp_code_e'(3'(i + 1));
        end
    end
endmodule

// File: rtl/lp_idle_fsm.sv
module lp_idle_fsm
    import lp_idle_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_busy,
    input  logic              exit_done,
    input  lp_code_e          target,
    output lp_code_e          code,
    output logic              gate,
    output logic              xreq,
    output logic [NUM_LP-1:0] stb,
    output logic              exiting
);
    lp_ctl_t ctl;

    always_ff @(posedge clk) begin
        if (rst) begin
            ctl <= '{code: LP_ACTIVE, phase: PH_RUN, gate: 1'b0, xreq: 1'b0};
            stb <= '0;
        end else begin
            stb <= '0;
            unique case (ctl.phase)
                PH_RUN: begin
                    if (ctl.code != LP_ACTIVE && bus_busy) begin
                        ctl.gate <= 1'b0;
                        if (ctl.gate) begin
                            ctl.phase <= PH_UNGATE;
                        end else begin
                            ctl.phase <= PH_WAIT;
                            ctl.xreq  <= 1'b1;
                        end
                    end else if (!bus_busy && target > ctl.code) begin
                        ctl.code <= target;
                        ctl.gate <= is_gated(target);
                        stb      <= stb_of(target);
                    end
                end
                PH_UNGATE: begin
                    ctl.phase <= PH_WAIT;
                    ctl.xreq  <= 1'b1;
                end
                PH_WAIT: begin
                    if (exit_done) begin
                        ctl.code  <= LP_ACTIVE;
                        ctl.phase <= PH_RUN;
                        ctl.xreq  <= 1'b0;
                    end
                end
                default: ctl.phase <= PH_RUN;
            endcase
        end
    end

    assign code    = ctl.code;
    assign gate    = ctl.gate;
    assign xreq    = ctl.xreq;
    assign exiting = (ctl.phase != PH_RUN);
endmodule

// File: rtl/lp_idle_ctrl.sv
module lp_idle_ctrl
    import lp_idle_pkg::*;
#(
    parameter int PD_W     = 8,
    parameter int SR_W     = 8,
    parameter int STBY_W   = 16,
    parameter int SCALE_SH = 10
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_busy,
    input  logic              mem_is_lp4,
    input  logic [PD_W-1:0]   lim_pdn,
    input  logic [SR_W-1:0]   lim_sref,
    input  logic [SR_W-1:0]   lim_sgate,
    input  logic [SR_W-1:0]   lim_spdn,
    input  logic [STBY_W-1:0] lim_stby,
    input  logic              exit_done,
    output logic              exit_req,
    output logic              clk_gate_en,
    output logic [NUM_LP-1:0] enter_stb,
    output logic [2:0]        st_code
);
    localparam int CNT_W = max3(PD_W, SR_W + SCALE_SH, STBY_W) + 1;

    logic [CNT_W-1:0] idle_cnt;
    lp_code_e         target;
    lp_code_e         code;
    logic             exiting;

    lp_idle_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk   (clk),
        .rst   (rst),
        .clear (bus_busy || exiting),
        .cnt   (idle_cnt)
    );

    lp_idle_select #(
        .PD_W(PD_W), .SR_W(SR_W), .STBY_W(STBY_W),
        .SCALE_SH(SCALE_SH), .CNT_W(CNT_W)
    ) u_sel (
        .clk        (clk),
        .rst        (rst),
        .load       (code == LP_ACTIVE),
        .mem_is_lp4 (mem_is_lp4),
        .lim_pdn    (lim_pdn),
        .lim_sref   (lim_sref),
        .lim_sgate  (lim_sgate),
        .lim_spdn   (lim_spdn),
        .lim_stby   (lim_stby),
        .cnt        (idle_cnt),
        .target     (target)
    );

    lp_idle_fsm u_fsm (
        .clk       (clk),
        .rst       (rst),
        .bus_busy  (bus_busy),
        .exit_done (exit_done),
        .target    (target),
        .code      (code),
        .gate      (clk_gate_en),
        .xreq      (exit_req),
        .stb       (enter_stb),
        .exiting   (exiting)
    );

    assign st_code = code;
endmodule

// File: rtl/lp_idle_ctrl_chk.sv
module lp_idle_ctrl_chk (
    input logic       clk,
    input logic       rst,
    input logic       mem_is_lp4,
    input logic       exit_done,
    input logic       exit_req,
    input logic       clk_gate_en,
    input logic [4:0] enter_stb,
    input logic [2:0] st_code
);
    AST_STB_ONEHOT: assert property (@(posedge clk) disable iff (rst)
        $onehot0(enter_stb)); // R11

    AST_STB_WITH_CHANGE: assert property (@(posedge clk) disable iff (rst)
        (enter_stb != 5'd0) |-> (st_code != $past(st_code))); // R11

    AST_DEEPER_ONLY: assert property (@(posedge clk) disable iff (rst)
        (st_code != $past(st_code) && st_code != 3'd0) |-> (st_code > $past(st_code))); // R7

    AST_GATE_STATES: assert property (@(posedge clk) disable iff (rst)
        clk_gate_en |-> (st_code >= 3'd3 && st_code <= 3'd5)); // R5

    AST_UNGATE_FIRST: assert property (@(posedge clk) disable iff (rst)
        exit_req |-> !clk_gate_en); // R8

    AST_XREQ_HOLD: assert property (@(posedge clk) disable iff (rst)
        (exit_req && !exit_done) |=> exit_req); // R8

    AST_DONE_TO_ACTIVE: assert property (@(posedge clk) disable iff (rst)
        (exit_req && exit_done) |=> (st_code == 3'd0 && !exit_req)); // R8

    AST_SRPD_LP4: assert property (@(posedge clk) disable iff (rst)
        enter_stb[3] |-> $past(mem_is_lp4)); // R4

    AST_CODE_RANGE: assert property (@(posedge clk) disable iff (rst)
        st_code <= 3'd5); // R10
endmodule

bind lp_idle_ctrl lp_idle_ctrl_chk u_chk (
    .clk         (clk),
    .rst         (rst),
    .mem_is_lp4  (mem_is_lp4),
    .exit_done   (exit_done),
    .exit_req    (exit_req),
    .clk_gate_en (clk_gate_en),
    .enter_stb   (enter_stb),
    .st_code     (st_code)
);

// File: tb/lp_idle_ctrl_bench.sv
module lp_idle_ctrl_bench;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        bus_busy = 1'b1;
    logic        mem_is_lp4 = 1'b1;
    logic [7:0]  lim_pdn = '0;
    logic [7:0]  lim_sref = '0;
    logic [7:0]  lim_sgate = '0;
    logic [7:0]  lim_spdn = '0;
    logic [15:0] lim_stby = '0;
    logic        exit_done = 1'b0;
    logic        exit_req;
    logic        clk_gate_en;
    logic [4:0]  enter_stb;
    logic [2:0]  st_code;

    int unsigned cyc = 0;
    int checks = 0;
    int errors = 0;
    bit done = 0;

    typedef struct {
        logic [2:0]  code;
        logic        gate;
        int unsigned at;
        string       req;
    } exp_t;
    exp_t q[$];
    logic [2:0] prev_code;

    always #4 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    lp_idle_ctrl u_lp_idle_ctrl (
        .clk(clk), .rst(rst), .bus_busy(bus_busy), .mem_is_lp4(mem_is_lp4),
        .lim_pdn(lim_pdn), .lim_sref(lim_sref), .lim_sgate(lim_sgate),
        .lim_spdn(lim_spdn), .lim_stby(lim_stby), .exit_done(exit_done),
        .exit_req(exit_req), .clk_gate_en(clk_gate_en),
        .enter_stb(enter_stb), .st_code(st_code)
    );

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s act=%0d exp=%0d (cycle %0d)", req, act, exp, cyc);
        end
    endtask

    task automatic expect_at(input logic [2:0] c, input logic g,
                             input int unsigned t, input string req);
        exp_t e;
        e.code = c; e.gate = g; e.at = t; e.req = req;
        q.push_back(e);
    endtask

    task automatic wait_until(input int unsigned t);
        while (cyc < t) @(negedge clk);
    endtask

    // Monitor: each state code change is matched against the queue
    always @(negedge clk) begin
        if (rst) begin
            prev_code <= 3'd0;
        end else begin
            if (st_code != prev_code) begin
                if (q.size() == 0) begin
                    check("R7 unexpected code change", int'(st_code), int'(prev_code));
                end else begin
                    exp_t e;
                    e = q.pop_front();
                    check({e.req, " code"}, int'(st_code), int'(e.code));
                    check({e.req, " cycle"}, int'(cyc), int'(e.at));
                    check({e.req, " R5 gate"}, int'(clk_gate_en), int'(e.gate));
                    if (st_code != 3'd0)
                        check("R11 strobe", int'(enter_stb), int'(5'd1 << (st_code - 3'd1)));
                    else
                        check("R11 strobe idle", int'(enter_stb), 0);
                end
            end
            prev_code <= st_code;
        end
    end

    task automatic summary;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL R8 watchdog act=hung exp=finished");
            summary();
            $finish;
        end
    end

    initial begin
        int unsigned e0;
        repeat (4) @(negedge clk);
        // R1 reset state
        check("R1 code", int'(st_code), 0);
        check("R1 strobe", int'(enter_stb), 0);
        check("R1 gate", int'(clk_gate_en), 0);
        check("R1 exit_req", int'(exit_req), 0);
        rst = 1'b0;

        // Scenario A: full cascade, LPDDR4
        lim_pdn = 8'd4; lim_sref = 8'd1; lim_sgate = 8'd2; lim_spdn = 8'd3;
        lim_stby = 16'd4000; mem_is_lp4 = 1'b1;
        repeat (3) @(negedge clk);
        bus_busy = 1'b0; e0 = cyc;
        expect_at(3'd1, 1'b0, e0 + 5,    "R2 pdown");
        expect_at(3'd2, 1'b0, e0 + 1025, "R3 sref");
        expect_at(3'd3, 1'b1, e0 + 2049, "R3 sref gate");
        expect_at(3'd4, 1'b1, e0 + 3073, "R4 srpd lp4");
        expect_at(3'd5, 1'b1, e0 + 4001, "R5 standby");
        wait_until(e0 + 4010);
        check("R5 gate in standby", int'(clk_gate_en), 1);
        // R8 exit with gating
        bus_busy = 1'b1;
        @(negedge clk);
        check("R8 gate dropped first", int'(clk_gate_en), 0);
        check("R8 no req yet", int'(exit_req), 0);
        check("R8 code held", int'(st_code), 5);
        @(negedge clk);
        check("R8 req raised", int'(exit_req), 1);
        repeat (3) @(negedge clk);
        check("R8 req held", int'(exit_req), 1);
        check("R8 code held in wait", int'(st_code), 5);
        exit_done = 1'b1;
        expect_at(3'd0, 1'b0, cyc + 1, "R8 back active");
        @(negedge clk);
        exit_done = 1'b0;
        check("R8 req released", int'(exit_req), 0);

        // Scenario B: not LPDDR4, zero limits, limits frozen while low-power
        lim_pdn = 8'd0; lim_sref = 8'd1; lim_sgate = 8'd0; lim_spdn = 8'd2;
        lim_stby = 16'd0; mem_is_lp4 = 1'b0;
        repeat (3) @(negedge clk);
        bus_busy = 1'b0; e0 = cyc;
        expect_at(3'd2, 1'b0, e0 + 1025, "R6 sref only");
        wait_until(e0 + 1100);
        lim_stby = 16'd5;   // R9 must not take effect now
        wait_until(e0 + 3200);
        check("R4 srpd skipped without lp4", int'(st_code), 2);
        check("R9 limit change ignored", int'(st_code), 2);
        bus_busy = 1'b1;
        @(negedge clk);
        check("R8 req without gating", int'(exit_req), 1);
        check("R8 gate low", int'(clk_gate_en), 0);
        exit_done = 1'b1;
        expect_at(3'd0, 1'b0, cyc + 1, "R8 back active B");
        @(negedge clk);
        exit_done = 1'b0;
        repeat (2) @(negedge clk);
        // R7 skip straight to deepest; R9 new limit now captured
        bus_busy = 1'b0; e0 = cyc;
        expect_at(3'd5, 1'b1, e0 + 6, "R7 skip to standby");
        wait_until(e0 + 12);
        bus_busy = 1'b1;
        @(negedge clk);
        @(negedge clk);
        check("R8 req after ungate", int'(exit_req), 1);
        exit_done = 1'b1;
        expect_at(3'd0, 1'b0, cyc + 1, "R8 back active C");
        @(negedge clk);
        exit_done = 1'b0;

        // Scenario C: busy pulse restarts count
        lim_pdn = 8'd20; lim_sref = 8'd0; lim_sgate = 8'd0; lim_spdn = 8'd0;
        lim_stby = 16'd0;
        repeat (3) @(negedge clk);
        bus_busy = 1'b0;
        repeat (10) @(negedge clk);
        bus_busy = 1'b1;
        @(negedge clk);
        bus_busy = 1'b0; e0 = cyc;
        expect_at(3'd1, 1'b0, e0 + 21, "R7 count restart");
        wait_until(e0 + 80);
        check("R6 stays in pdown", int'(st_code), 1);
        bus_busy = 1'b1;
        @(negedge clk);
        exit_done = 1'b1;
        expect_at(3'd0, 1'b0, cyc + 1, "R8 pdown exit");
        @(negedge clk);
        exit_done = 1'b0;
        repeat (4) @(negedge clk);
        check("R10 queue drained", q.size(), 0);
        done = 1;
        summary();
        $finish;
    end
endmodule